// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is a single input port of a wormhole router that carries traffic on several virtual channels. Each incoming flit has a kind and a virtual-channel number. The port stores the flit in a small queue that belongs to that channel. A state record for each channel moves every packet through four ordered stages: route computation, output virtual-channel allocation, switch allocation and switch traversal. Only a head flit is routed and asks for an output channel. Body and tail flits reuse the output port and output channel that their packet already holds, and they only compete for the switch.

The allocators outside the port see one virtual-channel request per channel, together with the computed output port. They also see one switch request per cycle, chosen round-robin among the ready channels of this port. A granted flit leaves through a registered output toward the crossbar. The departure of a tail flit returns its channel to idle. The upstream side reads a free-slot count per channel and sends a flit only when that count is non-zero.

When the speculative mode input is set, a waiting head flit asks for the switch in the same cycle as its output-channel request. It leaves only when both are granted together.

Top module: `vcr_input_port`

## Requirements
- R1: After reset every channel is idle. No allocation request is raised, `out_valid_o` is 0, and every free-slot count equals the queue depth.
- R2: A head flit that is written at clock edge k is routed in the cycle after that edge. Its channel raises `va_req_o` with the computed port from edge k+1 onward.
- R3: A channel keeps `va_req_o` and its port stable until `va_gnt_i` is seen for it. The granted output channel is taken from that channel's field of `va_vc_i`, and all flits of the packet carry it on `out_vc_o`.
- R4: Body (kind 1) and tail (kind 2) flits never raise a channel request. They leave with the port and output channel of the head (kind 0) that opened their packet.
- R5: In normal mode a head takes four cycles when there is no contention. It requests the switch the cycle after its channel grant, and `out_valid_o` shows the flit the cycle after the switch grant. Each later flit of the packet leaves one cycle after the one before it.
- R6: A flit whose switch request is refused stays at the front of its queue and blocks the flits behind it. The flits of one channel leave in arrival order.
- R7: When a tail leaves, its channel returns to idle. The next head on that channel goes through routing and channel allocation again.
- R8: A single-flit packet (kind 3) is routed, obtains a channel and frees it in one pass.
- R9: In speculative mode a waiting head requests the switch in the same cycle as its channel request. The flit leaves only if both grants arrive together, which makes the head latency three cycles. A switch grant without a channel grant moves no flit, and both requests are retried.
- R10: `sa_req_o` is raised when any channel is ready. A channel is ready when it holds a flit and either has an output channel, or is waiting for one in speculative mode. The chosen channel rotates round-robin, starting after the last channel that received a switch grant.
- R11: `free_slots_o` holds, per channel at bits [v*3 +: 3], the queue depth minus the number of stored flits.
- R12: Routing is dimension-ordered, X before Y. The destination x is in data bits [1:0] and y in bits [3:2], and the router sits at (1,1). The port codes are 1 for larger x, 2 for smaller x, 3 for larger y, 4 for smaller y, and 0 for local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spec_mode_i | input | 1 | Overlap channel and switch allocation |
| in_valid_i | input | 1 | Incoming flit valid |
| in_kind_i | input | 2 | Flit kind: 0 head, 1 body, 2 tail, 3 single |
| in_vc_i | input | 1 | Input channel of the flit |
| in_data_i | input | 16 | Flit payload; head carries the destination |
| free_slots_o | output | 6 | Free queue slots, 3 bits per channel |
| va_req_o | output | 2 | Output-channel request per input channel |
| va_port_o | output | 6 | Requested output port, 3 bits per channel |
| va_gnt_i | input | 2 | Output-channel grant per input channel |
| va_vc_i | input | 2 | Granted output channel, 1 bit per channel |
| sa_req_o | output | 1 | Switch request |
| sa_port_o | output | 3 | Output port of the switch request |
| sa_gnt_i | input | 1 | Switch grant |
| out_valid_o | output | 1 | Flit in switch traversal |
| out_kind_o | output | 2 | Kind of the leaving flit |
| out_port_o | output | 3 | Output port of the leaving flit |
| out_vc_o | output | 1 | Output channel of the leaving flit |
| out_data_o | output | 16 | Payload of the leaving flit |

## Verification
A four-flit packet with every grant given measures the stage timing in normal and in speculative mode. Withheld channel grants and alternating switch refusals then show stall propagation and in-order delivery. Two channels loaded at the same time show round-robin rotation and the output-channel labelling, through the different output channels handed to each. Single-flit packets sent to each of the five destinations test routing and same-pass release. A back-to-back second packet on a channel tests re-routing after a tail, and a full queue with the switch blocked tests the free-slot count.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  typedef enum logic [1:0] {
    FK_HEAD   = 2'd0,
    FK_BODY   = 2'd1,
    FK_TAIL   = 2'd2,
    FK_SINGLE = 2'd3
  } flit_kind_e;

  typedef enum logic [1:0] {
    VS_IDLE,
    VS_ROUTING,
    VS_WAIT_VC,
    VS_ACTIVE
  } vc_state_e;

  localparam int unsigned PORT_W = 3;

  localparam logic [PORT_W-1:0] P_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] P_XPOS  = 3'd1;
  localparam logic [PORT_W-1:0] P_XNEG  = 3'd2;
  localparam logic [PORT_W-1:0] P_YPOS  = 3'd3;
  localparam logic [PORT_W-1:0] P_YNEG  = 3'd4;

  function automatic logic closes_packet(logic [1:0] kind);
    return (kind == FK_TAIL) || (kind == FK_SINGLE);
  endfunction
endpackage

// File: rtl/vcr_fifo.sv
module vcr_fifo #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             rd_i,
  output logic [W-1:0]     rdata_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] free_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= bump(wp_q);
      if (rd_i) rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CNT_W'(wr_i) - CNT_W'(rd_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign free_o  = CNT_W'(DEPTH) - cnt_q;

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (free_o != '0));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/vcr_route.sv
module vcr_route
  import vcr_pkg::*;
#(
  parameter int unsigned CW    = 2,
  parameter int unsigned X_POS = 1,
  parameter int unsigned Y_POS = 1
) (
  input  logic [CW-1:0]     dest_x_i,
  input  logic [CW-1:0]     dest_y_i,
  output logic [PORT_W-1:0] port_o
);
  // X first, then Y
  always_comb begin
    if (dest_x_i > CW'(X_POS))      port_o = P_XPOS;
    else if (dest_x_i < CW'(X_POS)) port_o = P_XNEG;
    else if (dest_y_i > CW'(Y_POS)) port_o = P_YPOS;
    else if (dest_y_i < CW'(Y_POS)) port_o = P_YNEG;
    else                            port_o = P_LOCAL;
  end
endmodule

// File: rtl/vcr_vc_ctrl.sv
module vcr_vc_ctrl
  import vcr_pkg::*;
#(
  parameter int unsigned CW    = 2,
  parameter int unsigned VCW   = 1,
  parameter int unsigned X_POS = 1,
  parameter int unsigned Y_POS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spec_i,
  input  logic              wr_i,
  input  logic              empty_i,
  input  logic [1:0]        front_kind_i,
  input  logic [CW-1:0]     dest_x_i,
  input  logic [CW-1:0]     dest_y_i,
  input  logic              va_gnt_i,
  input  logic [VCW-1:0]    va_vc_i,
  input  logic              sa_win_i,
  output logic [PORT_W-1:0] port_o,
  output logic [VCW-1:0]    ovc_o,
  output logic              va_req_o,
  output logic              sa_elig_o,
  output logic              pop_o
);
  vc_state_e         state_q, state_d;
  logic [PORT_W-1:0] port_q, port_d, route_port;
  logic [VCW-1:0]    ovc_q, ovc_d;
  logic              closing;

  vcr_route #(.CW(CW), .X_POS(X_POS), .Y_POS(Y_POS)) u_route (
    .dest_x_i (dest_x_i),
    .dest_y_i (dest_y_i),
    .port_o   (route_port)
  );

  assign closing   = closes_packet(front_kind_i);
  assign va_req_o  = (state_q == VS_WAIT_VC);
  assign sa_elig_o = !empty_i && ((state_q == VS_ACTIVE) || (spec_i && state_q == VS_WAIT_VC));
  assign pop_o     = sa_win_i && ((state_q == VS_ACTIVE) ||
                                  (spec_i && state_q == VS_WAIT_VC && va_gnt_i));
  assign port_o    = port_q;
  assign ovc_o     = (state_q == VS_ACTIVE) ? ovc_q : va_vc_i;

  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    ovc_d   = ovc_q;
    unique case (state_q)
      VS_IDLE:    if (wr_i || !empty_i) state_d = VS_ROUTING;
      VS_ROUTING: begin
        port_d  = route_port;
        state_d = VS_WAIT_VC;
      end
      VS_WAIT_VC: if (va_gnt_i) begin
        ovc_d   = va_vc_i;
        state_d = (pop_o && closing) ? VS_IDLE : VS_ACTIVE;
      end
      VS_ACTIVE:  if (pop_o && closing) state_d = VS_IDLE;
      default:    state_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VS_IDLE;
      port_q  <= P_LOCAL;
      ovc_q   <= '0;
    end else begin
      state_q <= state_d;
      port_q  <= port_d;
      ovc_q   <= ovc_d;
    end
  end

  assert_routing_has_flit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == VS_ROUTING) |-> !empty_i);
  assert_va_after_rc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == VS_WAIT_VC) |-> ($past(state_q) == VS_ROUTING || $past(state_q) == VS_WAIT_VC));
  assert_va_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (va_req_o && !va_gnt_i) |=> (va_req_o && $stable(port_o)));
  assert_tail_frees_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && closing) |=> (state_q == VS_IDLE));
  assert_pop_needs_vc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> ((state_q == VS_ACTIVE) || (spec_i && va_gnt_i)));
endmodule

// File: rtl/vcr_sa_arb.sv
module vcr_sa_arb #(
  parameter int unsigned N = 2,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] elig_i,
  input  logic         gnt_i,
  output logic         req_o,
  output logic [N-1:0] sel_o
);
  logic [IW-1:0] ptr_q, ptr_d;

  assign req_o = |elig_i;

  // first eligible channel after the last winner
  always_comb begin
    sel_o = '0;
    for (int i = 1; i <= int'(N); i++) begin
      if (sel_o == '0 && elig_i[(int'(ptr_q) + i) % int'(N)])
        sel_o[(int'(ptr_q) + i) % int'(N)] = 1'b1;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < int'(N); i++) begin
      if (sel_o[i]) ptr_d = IW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= IW'(N - 1);
    else if (req_o && gnt_i) ptr_q <= ptr_d;
  end

  assert_single_pick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  assert_pick_is_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((sel_o & elig_i) != '0));
endmodule

// File: rtl/vcr_input_port.sv
module vcr_input_port
  import vcr_pkg::*;
#(
  parameter int unsigned NUM_VC     = 2,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CW         = 2,
  parameter int unsigned X_POS      = 1,
  parameter int unsigned Y_POS      = 1,
  localparam int unsigned VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned FW    = DATA_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     spec_mode_i,
  input  logic                     in_valid_i,
  input  logic [1:0]               in_kind_i,
  input  logic [VCW-1:0]           in_vc_i,
  input  logic [DATA_W-1:0]        in_data_i,
  output logic [NUM_VC*CNT_W-1:0]  free_slots_o,
  output logic [NUM_VC-1:0]        va_req_o,
  output logic [NUM_VC*PORT_W-1:0] va_port_o,
  input  logic [NUM_VC-1:0]        va_gnt_i,
  input  logic [NUM_VC*VCW-1:0]    va_vc_i,
  output logic                     sa_req_o,
  output logic [PORT_W-1:0]        sa_port_o,
  input  logic                     sa_gnt_i,
  output logic                     out_valid_o,
  output logic [1:0]               out_kind_o,
  output logic [PORT_W-1:0]        out_port_o,
  output logic [VCW-1:0]           out_vc_o,
  output logic [DATA_W-1:0]        out_data_o
);
  logic [FW-1:0]     front_w [NUM_VC];
  logic [PORT_W-1:0] port_w  [NUM_VC];
  logic [VCW-1:0]    ovc_w   [NUM_VC];
  logic [NUM_VC-1:0] wr_w, empty_w, elig_w, sel_w, pop_w, win_w;

  vcr_sa_arb #(.N(NUM_VC)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig_w),
    .gnt_i  (sa_gnt_i),
    .req_o  (sa_req_o),
    .sel_o  (sel_w)
  );

  assign win_w = sel_w & {NUM_VC{sa_gnt_i}};

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CNT_W-1:0] free_w;

    assign wr_w[v] = in_valid_i && (in_vc_i == VCW'(v));

    vcr_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_w[v]),
      .wdata_i ({in_kind_i, in_data_i}),
      .rd_i    (pop_w[v]),
      .rdata_o (front_w[v]),
      .empty_o (empty_w[v]),
      .free_o  (free_w)
    );

    vcr_vc_ctrl #(.CW(CW), .VCW(VCW), .X_POS(X_POS), .Y_POS(Y_POS)) u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .spec_i       (spec_mode_i),
      .wr_i         (wr_w[v]),
      .empty_i      (empty_w[v]),
      .front_kind_i (front_w[v][FW-1:DATA_W]),
      .dest_x_i     (front_w[v][CW-1:0]),
      .dest_y_i     (front_w[v][2*CW-1:CW]),
      .va_gnt_i     (va_gnt_i[v]),
      .va_vc_i      (va_vc_i[v*VCW +: VCW]),
      .sa_win_i     (win_w[v]),
      .port_o       (port_w[v]),
      .ovc_o        (ovc_w[v]),
      .va_req_o     (va_req_o[v]),
      .sa_elig_o    (elig_w[v]),
      .pop_o        (pop_w[v])
    );

    assign free_slots_o[v*CNT_W +: CNT_W]   = free_w;
    assign va_port_o[v*PORT_W +: PORT_W]    = port_w[v];
  end

  always_comb begin
    sa_port_o = '0;
    for (int v = 0; v < int'(NUM_VC); v++) begin
      if (sel_w[v]) sa_port_o = port_w[v];
    end
  end

  // switch traversal register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_kind_o  <= '0;
      out_port_o  <= '0;
      out_vc_o    <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= |pop_w;
      for (int v = 0; v < int'(NUM_VC); v++) begin
        if (pop_w[v]) begin
          out_kind_o <= front_w[v][FW-1:DATA_W];
          out_port_o <= port_w[v];
          out_vc_o   <= ovc_w[v];
          out_data_o <= front_w[v][DATA_W-1:0];
        end
      end
    end
  end

  assert_st_follows_sa_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(sa_req_o && sa_gnt_i));
  assert_one_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_w));
endmodule

// File: tb/tb_vcr_input_port.sv
module tb_vcr_input_port;
  localparam int NV = 2;
  localparam int DEPTH = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni;
  logic          spec_mode_i;
  logic          in_valid_i;
  logic [1:0]    in_kind_i;
  logic [0:0]    in_vc_i;
  logic [DW-1:0] in_data_i;
  logic [5:0]    free_slots_o;
  logic [1:0]    va_req_o;
  logic [5:0]    va_port_o;
  logic [1:0]    va_gnt_i;
  logic [1:0]    va_vc_i;
  logic          sa_req_o;
  logic [2:0]    sa_port_o;
  logic          sa_gnt_i;
  logic          out_valid_o;
  logic [1:0]    out_kind_o;
  logic [2:0]    out_port_o;
  logic [0:0]    out_vc_o;
  logic [DW-1:0] out_data_o;

  vcr_input_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .spec_mode_i(spec_mode_i),
    .in_valid_i(in_valid_i), .in_kind_i(in_kind_i), .in_vc_i(in_vc_i), .in_data_i(in_data_i),
    .free_slots_o(free_slots_o), .va_req_o(va_req_o), .va_port_o(va_port_o),
    .va_gnt_i(va_gnt_i), .va_vc_i(va_vc_i), .sa_req_o(sa_req_o), .sa_port_o(sa_port_o),
    .sa_gnt_i(sa_gnt_i), .out_valid_o(out_valid_o), .out_kind_o(out_kind_o),
    .out_port_o(out_port_o), .out_vc_o(out_vc_o), .out_data_o(out_data_o)
  );

  // behavioural reference
  logic [DW+1:0] mq [NV][$];
  int    mst [NV];      // 0 idle, 1 routing, 2 wait vc, 3 active
  int    mport [NV];
  int    movc [NV];
  int    mptr;
  bit    m_ov;
  int    m_ok, m_op, m_ovc, m_od;
  bit    spec;
  bit    va_allow [NV];
  int    sa_mode;       // 0 never, 1 always, 2 every other cycle
  int    cyc;
  int    checks, fails;
  string tag;
  bit    done;

  function automatic int route(logic [DW-1:0] d);
    if (d[1:0] > 2'd1) return 1;
    if (d[1:0] < 2'd1) return 2;
    if (d[3:2] > 2'd1) return 3;
    if (d[3:2] < 2'd1) return 4;
    return 0;
  endfunction

  function automatic int vmap(int v);
    return v ^ 1;
  endfunction

  function automatic bit elig(int v);
    return mq[v].size() > 0 && (mst[v] == 3 || (spec && mst[v] == 2));
  endfunction

  function automatic int pick();
    for (int i = 1; i <= NV; i++) begin
      if (elig((mptr + i) % NV)) return (mptr + i) % NV;
    end
    return -1;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int c;
    for (int v = 0; v < NV; v++) begin
      check($sformatf("va_req%0d R3", v), int'(va_req_o[v]), int'(mst[v] == 2));
      if (mst[v] == 2) check($sformatf("va_port%0d R2", v), int'(va_port_o[v*3 +: 3]), mport[v]);
      check($sformatf("free%0d R11", v), int'(free_slots_o[v*3 +: 3]), DEPTH - mq[v].size());
    end
    c = pick();
    check("sa_req R10", int'(sa_req_o), int'(c >= 0));
    if (c >= 0) check("sa_port R10", int'(sa_port_o), mport[c]);
    check("out_valid R5", int'(out_valid_o), int'(m_ov));
    if (m_ov) begin
      check("out_kind R4", int'(out_kind_o), m_ok);
      check("out_port R12", int'(out_port_o), m_op);
      check("out_vc R3", int'(out_vc_o), m_ovc);
      check("out_data R6", int'(out_data_o), m_od);
    end
  endtask

  task automatic step();
    int c, pop;
    bit sg;
    logic [DW+1:0] f;
    c  = pick();
    sg = (sa_mode == 1) || (sa_mode == 2 && cyc % 2 == 0);
    spec_mode_i = spec;
    sa_gnt_i    = sg;
    for (int v = 0; v < NV; v++) va_gnt_i[v] = va_allow[v];
    pop = -1;
    if (c >= 0 && sg) begin
      mptr = c;
      if (mst[c] == 3 || (spec && mst[c] == 2 && va_allow[c])) pop = c;
    end
    m_ov = (pop >= 0);
    if (pop >= 0) begin
      f     = mq[pop][0];
      m_ok  = int'(f[DW+1:DW]);
      m_od  = int'(f[DW-1:0]);
      m_op  = mport[pop];
      m_ovc = (mst[pop] == 3) ? movc[pop] : vmap(pop);
    end
    for (int v = 0; v < NV; v++) begin
      bit ends;
      ends = (mq[v].size() > 0) && (mq[v][0][DW+1:DW] >= 2'd2);
      case (mst[v])
        0: if ((in_valid_i && int'(in_vc_i) == v) || mq[v].size() > 0) mst[v] = 1;
        1: begin mport[v] = route(mq[v][0][DW-1:0]); mst[v] = 2; end
        2: if (va_allow[v]) begin
             movc[v] = vmap(v);
             mst[v]  = (pop == v && ends) ? 0 : 3;
           end
        default: if (pop == v && ends) mst[v] = 0;
      endcase
    end
    if (pop >= 0) void'(mq[pop].pop_front());
    if (in_valid_i) mq[int'(in_vc_i)].push_back({in_kind_i, in_data_i});
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compare();
    in_valid_i = 1'b0;
  endtask

  task automatic push(int vc, int kind, int data);
    in_valid_i = 1'b1;
    in_vc_i    = 1'(vc);
    in_kind_i  = 2'(kind);
    in_data_i  = DW'(data);
    step();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; done = 0;
    mptr = NV - 1; m_ov = 0; spec = 0; sa_mode = 1;
    for (int v = 0; v < NV; v++) begin
      mst[v] = 0; mport[v] = 0; movc[v] = 0; va_allow[v] = 1;
    end
    rst_ni = 0; spec_mode_i = 0; in_valid_i = 0; in_kind_i = 0; in_vc_i = 0;
    in_data_i = 0; va_gnt_i = 0; va_vc_i = 2'b01; sa_gnt_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tag = "R1";
    compare();
    check("reset free R1", int'(free_slots_o), {3'd4, 3'd4});
    check("reset out R1", int'(out_valid_o), 0);

    // R5: four-stage head, then one flit per cycle; R4 body/tail reuse
    tag = "R5";
    push(0, 0, 16'h0003);
    push(0, 1, 16'h1111);
    push(0, 1, 16'h2222);
    push(0, 2, 16'h3333);
    check("head after four cycles R5", int'(out_valid_o), 1);
    check("head kind R5", int'(out_kind_o), 0);
    step();
    check("body next cycle R4", int'(out_kind_o), 1);
    run(4);

    // R7: second packet on same channel is re-routed
    tag = "R7";
    push(0, 0, 16'h0004);
    push(0, 2, 16'h5555);
    push(0, 0, 16'h000C);
    push(0, 2, 16'h6666);
    run(10);

    // R3: channel grant withheld
    tag = "R3";
    va_allow[1] = 0;
    push(1, 0, 16'h0008);
    push(1, 1, 16'h7777);
    push(1, 2, 16'h8888);
    run(4);
    check("va_req held R3", int'(va_req_o[1]), 1);
    check("no flit without vc R3", int'(out_valid_o), 0);
    va_allow[1] = 1;
    run(8);

    // R6: switch refused every other cycle
    tag = "R6";
    sa_mode = 2;
    push(1, 0, 16'h0001);
    push(1, 1, 16'h0A0A);
    push(1, 1, 16'h0B0B);
    push(1, 2, 16'h0C0C);
    run(14);
    sa_mode = 1;

    // R10: two channels compete
    tag = "R10";
    push(0, 0, 16'h0003);
    push(1, 0, 16'h000D);
    push(0, 1, 16'h00A1);
    push(1, 1, 16'h00B1);
    push(0, 2, 16'h00A2);
    push(1, 2, 16'h00B2);
    run(10);

    // R12, R8: single-flit packets to all five ports
    tag = "R12";
    push(0, 3, 16'h0005);
    run(5);
    check("single flit local R8", int'(out_port_o), 0);
    tag = "R8";
    push(0, 3, 16'h0007);
    push(1, 3, 16'h0004);
    push(0, 3, 16'h000D);
    push(1, 3, 16'h0001);
    run(10);

    // R11: full queue with switch blocked
    tag = "R11";
    sa_mode = 0;
    push(0, 0, 16'h0009);
    push(0, 1, 16'h0101);
    push(0, 1, 16'h0202);
    push(0, 2, 16'h0303);
    check("queue full R11", int'(free_slots_o[2:0]), 0);
    run(3);
    sa_mode = 1;
    run(8);

    // R9: speculative overlap
    tag = "R9";
    spec = 1;
    push(1, 3, 16'h0003);
    step();
    step();
    check("spec single after three cycles R9", int'(out_valid_o), 1);
    run(3);
    va_allow[0] = 0;
    push(0, 0, 16'h000C);
    push(0, 2, 16'h0F0F);
    run(5);
    check("switch slot wasted R9", int'(out_valid_o), 0);
    check("va retried R9", int'(va_req_o[0]), 1);
    va_allow[0] = 1;
    run(6);
    spec = 0;
    run(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule